// File: doc/BRIEF.md
# Multi-Match Timer with Snapshot

A register-mapped system timer built around a 64-bit up-counter. The counter advances on ticks from a programmable prescaler. Six 32-bit compare channels watch the low word of the count. Each channel has a sticky status bit that is cleared by writing 1 to it, and an interrupt enable bit. When the watchdog function is armed, channel 5 also produces a one-clock reset pulse.

Software reads a consistent 64-bit time value in two steps. It first writes a latch command, which copies the whole counter into two snapshot words in one clock. It then reads those two words at leisure. Both counter words can be loaded directly, and the divider sets the tick rate.

The bus is a single-cycle 32-bit write port with a word address and a combinational read port. Word index n corresponds to byte offset 4n.

Top module: `multi_match_timer`

## Requirements
- R1: After reset the following read as zero: the counter high word, all match words, status, interrupt enable, watchdog enable, divider and both snapshot words. `irq_o` and `wdt_rst_o` are low.
- R2: With divider value D (word 11), the counter advances once every 2*(D+1) clocks. A write to the divider restarts the prescaler phase: the first advance lands exactly 2*(D+1) clocks after that write's clock edge, and the write edge itself never advances the counter.
- R3: The counter is 64 bits wide and carries from the low word into the high word. A write to word 0 loads the low word and a write to word 1 loads the high word. A load cycle suppresses that cycle's advance.
- R4: A write to word 12 with bit 0 set copies the counter value from before that edge into word 13 (low half) and word 14 (high half). A write to word 12 with bit 0 clear leaves the snapshot unchanged. The snapshot holds until the next latch command.
- R5: Status bit n (word 8, bit n) sets on the advance that makes the counter's low word equal to match word n (word 2+n). The low word wraps modulo 2^32, and the bit stays set until it is cleared.
- R6: A write to word 8 clears every status bit whose data bit is 1. Status bits whose data bit is 0 are left unchanged.
- R7: `irq_o` is a registered OR over n of (status bit n AND enable bit n), with the enables at word 9, bit n. It follows status by one clock. Enable bits that are clear mask the interrupt and do not affect the count.
- R8: When bit 0 of word 10 is set, a channel 5 match drives `wdt_rst_o` high for exactly one clock, in the same clock that status bit 5 becomes visible. When that bit is clear, no pulse occurs.
- R9: Reads of word 12 and of word 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 4 | Word address (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Masked, registered interrupt |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
Any fault in the prescaler phase or the counter carry appears at the counter read port within one tick period. It also shifts the compare events by whole ticks, so the status and interrupt checks, which are sampled on exact cycles, expose it. A channel comparing against the wrong counter value, or a status register that loses W1C or stickiness, shows up in the status word within a clock of the expected event. Snapshot faults are exposed by reading the snapshot words against the value the count had on the command edge, including across a low-word carry. Interrupt or watchdog gating errors appear on `irq_o` or `wdt_rst_o` one clock later.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  localparam int NUM_CH = 6;
  localparam int WDT_CH = 5;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;

  typedef logic [IDX_W-1:0] reg_idx_t;

  localparam reg_idx_t IDX_CNT_LO = 4'd0;
  localparam reg_idx_t IDX_CNT_HI = 4'd1;
  localparam reg_idx_t IDX_MATCH0 = 4'd2;
  localparam reg_idx_t IDX_STATUS = 4'd8;
  localparam reg_idx_t IDX_IEN    = 4'd9;
  localparam reg_idx_t IDX_WDEN   = 4'd10;
  localparam reg_idx_t IDX_DIV    = 4'd11;
  localparam reg_idx_t IDX_LATCH  = 4'd12;
  localparam reg_idx_t IDX_LAT_LO = 4'd13;
  localparam reg_idx_t IDX_LAT_HI = 4'd14;
endpackage

// File: rtl/mmt_prescaler.sv
module mmt_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  localparam int PC_W = DIV_W + 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] term;

  // period is 2*(div+1): terminal phase is 2*div+1
  assign term   = {div_i, 1'b1};
  assign tick_o = (pc_q == term) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pc_q <= '0;
    else if (restart_i)        pc_q <= '0;
    else if (pc_q == term)     pc_q <= '0;
    else                       pc_q <= pc_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R2
  AST_RESTART_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o); // R2
endmodule

// File: rtl/mmt_counter.sv
module mmt_counter #(
  parameter int W = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           ld_lo_i,
  input  logic           ld_hi_i,
  input  logic [W-1:0]   wdata_i,
  input  logic           snap_i,
  output logic [2*W-1:0] cnt_o,
  output logic [2*W-1:0] lat_o,
  output logic [W-1:0]   next_lo_o
);
  localparam int CW = 2 * W;

  logic [CW-1:0] cnt_q, lat_q;
  logic          load;

  assign load      = ld_lo_i || ld_hi_i;
  assign next_lo_o = cnt_q[W-1:0] + 1'b1;
  assign cnt_o     = cnt_q;
  assign lat_o     = lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load) begin
      if (ld_lo_i) cnt_q[W-1:0]  <= wdata_i;
      if (ld_hi_i) cnt_q[CW-1:W] <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= '0;
    else if (snap_i) lat_q <= cnt_q;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load) |=> cnt_q == $past(cnt_q) + 1'b1); // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load) |=> $stable(cnt_q)); // R3
  AST_SNAP_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> lat_q == $past(cnt_q)); // R4
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(lat_q)); // R4
endmodule

// File: rtl/mmt_match.sv
module mmt_match #(
  parameter int NUM_CH = 6,
  parameter int W      = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic                       load_i,
  input  logic [W-1:0]               next_lo_i,
  input  logic [NUM_CH-1:0]          match_wr_i,
  input  logic [W-1:0]               wdata_i,
  input  logic [NUM_CH-1:0]          clr_i,
  output logic [NUM_CH-1:0][W-1:0]   match_o,
  output logic [NUM_CH-1:0]          hit_o,
  output logic [NUM_CH-1:0]          status_o
);
  logic [NUM_CH-1:0] status_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [W-1:0] m_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           m_q <= '0;
      else if (match_wr_i[g]) m_q <= wdata_i;
    end
    assign match_o[g] = m_q;
    // compare against the value the counter is about to take
    assign hit_o[g]   = tick_i && !load_i && (next_lo_i == m_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | hit_o;
  end
  assign status_o = status_q;

  AST_HIT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hit_o) |=> ((status_q & $past(hit_o)) == $past(hit_o))); // R5
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~status_q & $past(status_q & ~clr_i)) == '0)); // R5
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((status_q & $past(clr_i & ~hit_o)) == '0)); // R6
endmodule

// File: rtl/multi_match_timer.sv
module multi_match_timer
  import mmt_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              wdt_rst_o
);
  logic wr_lo, wr_hi, wr_status, wr_ien, wr_wden, wr_div, snap;
  logic [NUM_CH-1:0] match_wr, clr, hit, status;
  logic [NUM_CH-1:0][DATA_W-1:0] match;
  logic [2*DATA_W-1:0] cnt, lat;
  logic [DATA_W-1:0] next_lo;
  logic tick;

  logic [NUM_CH-1:0] ien_q;
  logic              wden_q;
  logic [DIV_W-1:0]  div_q;
  logic              irq_q, wdt_q;

  assign wr_lo     = wr_en_i && (addr_i == IDX_CNT_LO);
  assign wr_hi     = wr_en_i && (addr_i == IDX_CNT_HI);
  assign wr_status = wr_en_i && (addr_i == IDX_STATUS);
  assign wr_ien    = wr_en_i && (addr_i == IDX_IEN);
  assign wr_wden   = wr_en_i && (addr_i == IDX_WDEN);
  assign wr_div    = wr_en_i && (addr_i == IDX_DIV);
  assign snap      = wr_en_i && (addr_i == IDX_LATCH) && wdata_i[0];
  assign clr       = wr_status ? wdata_i[NUM_CH-1:0] : '0;

  always_comb begin
    for (int n = 0; n < NUM_CH; n++)
      match_wr[n] = wr_en_i && (addr_i == IDX_MATCH0 + reg_idx_t'(n));
  end

  mmt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i, .rst_ni, .div_i(div_q), .restart_i(wr_div), .tick_o(tick)
  );

  mmt_counter #(.W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .ld_lo_i(wr_lo), .ld_hi_i(wr_hi),
    .wdata_i, .snap_i(snap), .cnt_o(cnt), .lat_o(lat), .next_lo_o(next_lo)
  );

  mmt_match #(.NUM_CH(NUM_CH), .W(DATA_W)) u_match (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(wr_lo || wr_hi),
    .next_lo_i(next_lo), .match_wr_i(match_wr), .wdata_i, .clr_i(clr),
    .match_o(match), .hit_o(hit), .status_o(status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      wden_q <= 1'b0;
      div_q  <= '0;
      irq_q  <= 1'b0;
      wdt_q  <= 1'b0;
    end else begin
      if (wr_ien)  ien_q  <= wdata_i[NUM_CH-1:0];
      if (wr_wden) wden_q <= wdata_i[0];
      if (wr_div)  div_q  <= wdata_i[DIV_W-1:0];
      irq_q <= |(status & ien_q);
      wdt_q <= hit[WDT_CH] && wden_q;
    end
  end

  assign irq_o     = irq_q;
  assign wdt_rst_o = wdt_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      IDX_CNT_LO: rdata_o = cnt[DATA_W-1:0];
      IDX_CNT_HI: rdata_o = cnt[2*DATA_W-1:DATA_W];
      IDX_STATUS: rdata_o = {{(DATA_W-NUM_CH){1'b0}}, status};
      IDX_IEN:    rdata_o = {{(DATA_W-NUM_CH){1'b0}}, ien_q};
      IDX_WDEN:   rdata_o = {{(DATA_W-1){1'b0}}, wden_q};
      IDX_DIV:    rdata_o = {{(DATA_W-DIV_W){1'b0}}, div_q};
      IDX_LAT_LO: rdata_o = lat[DATA_W-1:0];
      IDX_LAT_HI: rdata_o = lat[2*DATA_W-1:DATA_W];
      default: begin
        for (int n = 0; n < NUM_CH; n++)
          if (addr_i == IDX_MATCH0 + reg_idx_t'(n)) rdata_o = match[n];
      end
    endcase
  end

  AST_WDT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R8
  AST_WDT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wden_q |=> !wdt_rst_o); // R8
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |=> !irq_o); // R7
endmodule

// File: tb/multi_match_timer_tb.sv
module multi_match_timer_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic irq_o, wdt_rst_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  multi_match_timer u_dut (.*);

  function automatic logic [63:0] exp_count(logic [63:0] l, int m, int d);
    return l + 64'(m / (2 * d + 2));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
  endtask

  task automatic done();
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic rd_cnt(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(4'd0, lo); rd(4'd1, hi);
    v = {hi, lo};
  endtask

  task automatic rd_lat(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(4'd13, lo); rd(4'd14, hi);
    v = {hi, lo};
  endtask

  // count = l, prescaler restarted with divider d; returns at m=0
  task automatic set_count(logic [63:0] l, int d);
    wr(4'd0, l[31:0]);
    wr(4'd1, l[63:32]);
    wr(4'd11, 32'(d));
    done();
  endtask

  task automatic run_match(int n, int d, int k, logic [63:0] l, bit ien_on, bit wden_on);
    logic [31:0] r;
    logic [63:0] c;
    int p;
    p = 2 * d + 2;
    wr(4'(2 + n), l[31:0] + 32'(k));
    wr(4'd9, ien_on ? (32'd1 << n) : 32'd0);
    wr(4'd10, 32'(wden_on));
    wr(4'd8, 32'h3F);
    wr(4'd0, l[31:0]);
    wr(4'd1, l[63:32]);
    wr(4'd11, 32'(d));
    done();
    repeat (k * p - 1) @(negedge clk_i);
    rd(4'd8, r);
    chk("R5 status before match", 64'(r[n]), 64'd0);
    chk("R7 irq before match", 64'(irq_o), 64'd0);
    chk("R8 wdt before match", 64'(wdt_rst_o), 64'd0);
    rd_cnt(c);
    chk("R2 count before match", c, exp_count(l, k * p - 1, d));
    @(negedge clk_i);
    rd(4'd8, r);
    chk("R5 status at match", 64'(r[n]), 64'd1);
    chk("R8 wdt at match", 64'(wdt_rst_o), 64'(n == 5 && wden_on));
    chk("R7 irq lags status", 64'(irq_o), 64'd0);
    rd_cnt(c);
    chk("R3 count at match", c, l + 64'(k));
    @(negedge clk_i);
    chk("R7 irq after match", 64'(irq_o), 64'(ien_on));
    chk("R8 wdt single pulse", 64'(wdt_rst_o), 64'd0);
    wr(4'd8, 32'd0);
    done();
    rd(4'd8, r);
    chk("R6 write 0 keeps status", 64'(r[n]), 64'd1);
    wr(4'd8, 32'd1 << n);
    done();
    rd(4'd8, r);
    chk("R6 write 1 clears status", 64'(r[n]), 64'd0);
    @(negedge clk_i);
    chk("R7 irq drops after clear", 64'(irq_o), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [63:0] c, v, l;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(4'd1, r);  chk("R1 count hi", 64'(r), 64'd0);
    for (int i = 2; i < 12; i++) begin
      rd(4'(i), r); chk("R1 register zero", 64'(r), 64'd0);
    end
    rd_lat(v); chk("R1 snapshot", v, 64'd0);
    chk("R1 irq", 64'(irq_o), 64'd0);
    chk("R1 wdt", 64'(wdt_rst_o), 64'd0);

    // R9 reserved reads
    rd(4'd12, r); chk("R9 latch word reads 0", 64'(r), 64'd0);
    rd(4'd15, r); chk("R9 unused word reads 0", 64'(r), 64'd0);

    // R2 prescaler period with D=3
    l = 64'h0000_0001_0000_0010;
    set_count(l, 3);
    rd_cnt(c); chk("R2 count at restart", c, l);
    repeat (7) @(negedge clk_i);
    rd_cnt(c); chk("R2 no advance before period", c, l);
    @(negedge clk_i);
    rd_cnt(c); chk("R2 first advance", c, l + 64'd1);
    repeat (8) @(negedge clk_i);
    rd_cnt(c); chk("R2 second advance", c, l + 64'd2);

    // R4 snapshot across low-word carry, D=2 (period 6)
    l = 64'h0000_00AB_FFFF_FFFF;
    set_count(l, 2);
    wr(4'd12, 32'd1);
    done();
    rd_lat(v); chk("R4 snapshot value", v, l);
    repeat (10) @(negedge clk_i);
    rd_cnt(c); chk("R3 carry into high word", c, l + 64'd2);
    rd_lat(v); chk("R4 snapshot holds", v, l);
    wr(4'd12, 32'd0);
    done();
    rd_lat(v); chk("R4 bit0 clear ignored", v, l);
    wr(4'd12, 32'd1);
    done();
    rd_lat(v); chk("R4 second snapshot", v, l + 64'd2);

    // directed: watchdog armed and disarmed, low-word wrap
    run_match(5, 1, 2, 64'h0000_0003_FFFF_FFFF, 1'b1, 1'b1);
    run_match(5, 0, 1, 64'h0000_0000_1234_5678, 1'b0, 1'b0);
    run_match(0, 0, 3, 64'h7FFF_FFFF_FFFF_FFFE, 1'b1, 1'b0);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int n, d, k;
      logic [63:0] lr;
      n = int'($urandom_range(5, 0));
      d = int'($urandom_range(3, 0));
      k = int'($urandom_range(4, 1));
      lr = {$urandom(), $urandom()};
      if (it % 4 == 0) lr[31:0] = 32'hFFFF_FFFF - 32'($urandom_range(3, 0));
      run_match(n, d, k, lr, 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule